// File: doc/BRIEF.md
# Cache-Blocked Memory Operation Replay Queue

This block sits between an instruction issue scheduler and the request port of a data cache. When the cache turns away a memory operation, the scheduler pushes that operation's tag, thread and sequence number into the queue. The entry then waits in a blocked list. It is not visible to the scheduler while it waits there. The pipeline is neither squashed nor refetched for it.

When the cache later signals that it can accept requests again, one retry pulse releases every blocked entry at once. The released entries keep their order and are appended to a retry list. The scheduler drains that list from the head, one entry per taken cycle, and does so before it picks normal ready instructions. An entry that is turned away again is simply pushed back as blocked.

The same retry pulse does two more things. It produces a wake pulse for the core clocking logic, and it is forwarded to every active thread. A per-thread squash by sequence number removes younger entries from both lists. A synchronous flush empties the queue. An activity output tells the core whether the issue stage has anything to do.

Top module: `rq_top`

## Requirements
- R1: A pushed entry is held as blocked. While no retry pulse has arrived since it was pushed, `replay_valid` stays 0 for it.
- R2: A `cache_retry` pulse moves every blocked entry, in push order, behind the entries already waiting to replay. An entry pushed in the same cycle as the pulse is included. The moved entries are visible from the next cycle.
- R3: `wake` is 1 in exactly the cycle after each cycle in which `cache_retry` is 1.
- R4: `thread_retry` equals the `active_mask` sampled with a retry pulse, one cycle later. It is 0 in every other cycle. Bit k of `thread_retry` corresponds to thread k.
- R5: `replay_valid` is 1 exactly when the retry list is non-empty, and `replay_tag`/`replay_seq`/`replay_tid` show its oldest entry. When `replay_take` is 1 while `replay_valid` is 1, that head entry is removed at the clock edge. With no take, squash or flush, the head stays unchanged.
- R6: An entry that is taken and pushed again is placed at the tail of the blocked list. It waits there until the next retry pulse.
- R7: `activity` is 1 exactly when `issued_any` is 1, or the retry list is non-empty, or `defer_pending` is 1. It is combinational in the current cycle.
- R8: A squash with thread T and sequence number N removes every stored entry of thread T whose sequence number is greater than N (unsigned compare) from both lists. All other entries keep their relative order. An entry pushed in the squash cycle is not affected.
- R9: After reset, and in the cycle after `flush` is 1, both lists are empty. A push in a flush cycle is dropped.
- R10: Both lists share DEPTH entries of storage. A push is never made when all DEPTH entries are in use, unless the head is taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of both lists |
| push_valid | input | 1 | A refused cache request is parked |
| push_tag | input | TAG_W | Tag of the refused operation |
| push_seq | input | SEQ_W | Sequence number of the refused operation |
| push_tid | input | TID_W | Thread of the refused operation |
| cache_retry | input | 1 | Cache is ready to accept requests again |
| active_mask | input | NTHR | Threads currently active |
| replay_take | input | 1 | Scheduler consumes the replay head |
| replay_valid | output | 1 | Retry list is non-empty |
| replay_tag | output | TAG_W | Tag of the replay head |
| replay_seq | output | SEQ_W | Sequence number of the replay head |
| replay_tid | output | TID_W | Thread of the replay head |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Entries younger than this are removed |
| issued_any | input | 1 | Scheduler issued something this cycle |
| defer_pending | input | 1 | Deferred-translation list is non-empty |
| activity | output | 1 | Issue stage has work |
| wake | output | 1 | One-cycle pulse after a cache retry |
| thread_retry | output | NTHR | Retry forwarded to each active thread |

## Verification
The checker watches several properties on every cycle:
- The wake pulse and the per-thread retry forwarding.
- That parked entries never show up without a retry.
- That a retry exposes a non-empty queue.
- That the head holds steady when it is not taken.
- That flush empties the queue.
- That no push lands in a full queue.
- That activity follows its inputs.

The order of entries across retries, re-blocking and squashes cannot be expressed as simple properties. The bench's reference model covers these. It compares every replayed entry against the model over directed scenarios and a long mixed sweep.

// File: rtl/rq_pkg.sv
package rq_pkg;
  parameter int unsigned TAG_W = 6;
  parameter int unsigned SEQ_W = 8;
  parameter int unsigned TID_W = 1;
  localparam int unsigned NTHR = 1 << TID_W;

  typedef struct packed {
    logic [TID_W-1:0] tid;
    logic [SEQ_W-1:0] seq;
    logic [TAG_W-1:0] tag;
  } rq_entry_t;
endpackage

// File: rtl/rq_keep.sv
module rq_keep
  import rq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  rq_entry_t        ent [DEPTH],
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] rcnt,
  input  logic             take,
  input  logic             sq_valid,
  input  logic [TID_W-1:0] sq_tid,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic [DEPTH-1:0] keep,
  output logic [CNT_W-1:0] kept_retry
);

  // An entry survives unless it is empty, squashed, or the taken head.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic occupied;
    logic squashed;
    logic popped;
    assign occupied = CNT_W'(i) < cnt;
    assign squashed = sq_valid && (ent[i].tid == sq_tid) && (ent[i].seq > sq_seq);
    if (i == 0) begin : g_head
      assign popped = take && (rcnt != '0);
    end else begin : g_body
      assign popped = 1'b0;
    end
    assign keep[i] = occupied && !squashed && !popped;
  end

  // Survivors that sat in the replay region stay in that region.
  always_comb begin
    kept_retry = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i] && (CNT_W'(i) < rcnt)) kept_retry = kept_retry + CNT_W'(1);
    end
  end

endmodule

// File: rtl/rq_compact.sv
module rq_compact
  import rq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  rq_entry_t        ent_in  [DEPTH],
  input  logic [DEPTH-1:0] keep,
  output rq_entry_t        ent_out [DEPTH],
  output logic [CNT_W-1:0] kept
);

  logic [CNT_W-1:0] pos [DEPTH+1];

  // Running count of survivors gives each survivor its new slot.
  always_comb begin
    pos[0] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      pos[i+1] = pos[i] + CNT_W'(keep[i]);
    end
  end

  assign kept = pos[DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_out
    always_comb begin
      ent_out[j] = '0;
      for (int i = j; i < DEPTH; i++) begin
        if (keep[i] && (pos[i] == CNT_W'(j))) ent_out[j] = ent_out[j] | ent_in[i];
      end
    end
  end

endmodule

// File: rtl/rq_top.sv
module rq_top
  import rq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_valid,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic [TID_W-1:0] push_tid,
  input  logic             cache_retry,
  input  logic [NTHR-1:0]  active_mask,
  input  logic             replay_take,
  output logic             replay_valid,
  output logic [TAG_W-1:0] replay_tag,
  output logic [SEQ_W-1:0] replay_seq,
  output logic [TID_W-1:0] replay_tid,
  input  logic             sq_valid,
  input  logic [TID_W-1:0] sq_tid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             issued_any,
  input  logic             defer_pending,
  output logic             activity,
  output logic             wake,
  output logic [NTHR-1:0]  thread_retry
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // Storage: slots [0, rcnt_q) form the retry list, [rcnt_q, cnt_q) the blocked list.
  rq_entry_t        ent_q [DEPTH];
  rq_entry_t        ent_n [DEPTH];
  rq_entry_t        ent_c [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] rcnt_q, rcnt_n;
  logic             wake_q;
  logic [NTHR-1:0]  thr_q;
  logic [DEPTH-1:0] keep;
  logic [CNT_W-1:0] kept, kept_retry;
  logic             ent_en;
  logic             push_ok;
  rq_entry_t        push_ent;

  rq_keep #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_keep (
    .ent        (ent_q),
    .cnt        (cnt_q),
    .rcnt       (rcnt_q),
    .take       (replay_take),
    .sq_valid   (sq_valid),
    .sq_tid     (sq_tid),
    .sq_seq     (sq_seq),
    .keep       (keep),
    .kept_retry (kept_retry)
  );

  rq_compact #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_compact (
    .ent_in  (ent_q),
    .keep    (keep),
    .ent_out (ent_c),
    .kept    (kept)
  );

  assign push_ent = '{tid: push_tid, seq: push_seq, tag: push_tag};
  assign push_ok  = push_valid && (kept < CNT_W'(DEPTH));

  // Next state: compact, append push to blocked tail, then release on retry.
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      ent_n[j] = ent_c[j];
      if (push_ok && (kept == CNT_W'(j))) ent_n[j] = push_ent;
    end
    if (flush) begin
      cnt_n  = '0;
      rcnt_n = '0;
    end else begin
      cnt_n  = kept + CNT_W'(push_ok);
      rcnt_n = cache_retry ? cnt_n : kept_retry;
    end
  end

  assign ent_en = push_valid || (replay_take && replay_valid) || sq_valid;

  always_ff @(posedge clk) begin
    if (ent_en) ent_q <= ent_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rcnt_q <= '0;
      wake_q <= 1'b0;
      thr_q  <= '0;
    end else begin
      cnt_q  <= cnt_n;
      rcnt_q <= rcnt_n;
      wake_q <= cache_retry;
      thr_q  <= cache_retry ? active_mask : '0;
    end
  end

  assign replay_valid = rcnt_q != '0;
  assign replay_tag   = ent_q[0].tag;
  assign replay_seq   = ent_q[0].seq;
  assign replay_tid   = ent_q[0].tid;
  assign activity     = issued_any || replay_valid || defer_pending;
  assign wake         = wake_q;
  assign thread_retry = thr_q;

endmodule

// File: rtl/rq_checker.sv
module rq_checker
  import rq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             push_valid,
  input logic             cache_retry,
  input logic [NTHR-1:0]  active_mask,
  input logic             replay_take,
  input logic             replay_valid,
  input logic [TAG_W-1:0] replay_tag,
  input logic             sq_valid,
  input logic             issued_any,
  input logic             defer_pending,
  input logic             activity,
  input logic             wake,
  input logic [NTHR-1:0]  thread_retry,
  input logic [CNT_W-1:0] cnt_q
);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !flush |-> (cnt_q < CNT_W'(DEPTH)) || (replay_take && replay_valid));

  a_r3_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cache_retry |=> wake);

  a_r3_no_spurious_wake: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_retry |=> !wake);

  a_r4_forward: assert property (@(posedge clk) disable iff (!rst_n)
    cache_retry |=> thread_retry == $past(active_mask));

  a_r1_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !replay_valid && !cache_retry |=> !replay_valid);

  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    cache_retry && !flush && !sq_valid &&
    (push_valid || (cnt_q >= CNT_W'(2)) || ((cnt_q == CNT_W'(1)) && !(replay_take && replay_valid)))
    |=> replay_valid);

  a_r5_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid && !replay_take && !sq_valid && !flush |=> replay_valid && $stable(replay_tag));

  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !replay_valid && (cnt_q == '0));

  a_r7_activity: assert property (@(posedge clk) disable iff (!rst_n)
    issued_any || defer_pending |-> activity);

endmodule

bind rq_top rq_checker #(.DEPTH(DEPTH)) u_rq_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .push_valid    (push_valid),
  .cache_retry   (cache_retry),
  .active_mask   (active_mask),
  .replay_take   (replay_take),
  .replay_valid  (replay_valid),
  .replay_tag    (replay_tag),
  .sq_valid      (sq_valid),
  .issued_any    (issued_any),
  .defer_pending (defer_pending),
  .activity      (activity),
  .wake          (wake),
  .thread_retry  (thread_retry),
  .cnt_q         (cnt_q)
);

// File: tb/test_rq_top.sv
module test_rq_top;
  import rq_pkg::*;

  localparam int  DEPTH   = 8;
  localparam time CLK_PER = 10ns;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             flush, push_valid, cache_retry, replay_take;
  logic [TAG_W-1:0] push_tag;
  logic [SEQ_W-1:0] push_seq;
  logic [TID_W-1:0] push_tid;
  logic [NTHR-1:0]  active_mask;
  logic             replay_valid;
  logic [TAG_W-1:0] replay_tag;
  logic [SEQ_W-1:0] replay_seq;
  logic [TID_W-1:0] replay_tid;
  logic             sq_valid;
  logic [TID_W-1:0] sq_tid;
  logic [SEQ_W-1:0] sq_seq;
  logic             issued_any, defer_pending;
  logic             activity, wake;
  logic [NTHR-1:0]  thread_retry;

  always #(CLK_PER/2) clk = ~clk;

  rq_top #(.DEPTH(DEPTH)) i_rq_top (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_valid(push_valid),
    .push_tag(push_tag), .push_seq(push_seq), .push_tid(push_tid),
    .cache_retry(cache_retry), .active_mask(active_mask), .replay_take(replay_take),
    .replay_valid(replay_valid), .replay_tag(replay_tag), .replay_seq(replay_seq),
    .replay_tid(replay_tid), .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .issued_any(issued_any), .defer_pending(defer_pending), .activity(activity),
    .wake(wake), .thread_retry(thread_retry)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Reference model lists.
  rq_entry_t blk[$];
  rq_entry_t rty[$];
  logic            prev_retry = 1'b0;
  logic [NTHR-1:0] prev_mask  = '0;
  logic [SEQ_W-1:0] seq_ctr   = '0;
  int popped = 0;

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    flush = 0; push_valid = 0; cache_retry = 0; replay_take = 0; sq_valid = 0;
    issued_any = 0; defer_pending = 0;
  endtask

  // Inputs are already set for this cycle (driven after the last negedge).
  task automatic step();
    rq_entry_t tmp[$];
    #1;
    check("R7", "activity", int'(activity),
          int'(issued_any || (rty.size() != 0) || defer_pending));
    check("R5", "replay_valid", int'(replay_valid), int'(rty.size() != 0));
    if (rty.size() != 0) begin
      check("R2", "replay_tag", int'(replay_tag), int'(rty[0].tag));
      check("R2", "replay_seq", int'(replay_seq), int'(rty[0].seq));
      check("R2", "replay_tid", int'(replay_tid), int'(rty[0].tid));
    end
    check("R3", "wake", int'(wake), int'(prev_retry));
    check("R4", "thread_retry", int'(thread_retry), prev_retry ? int'(prev_mask) : 0);
    @(posedge clk);
    if (replay_take && rty.size() != 0) begin
      void'(rty.pop_front());
      popped++;
    end
    if (sq_valid) begin
      tmp = {};
      foreach (rty[i]) if (!(rty[i].tid == sq_tid && rty[i].seq > sq_seq)) tmp.push_back(rty[i]);
      rty = tmp;
      tmp = {};
      foreach (blk[i]) if (!(blk[i].tid == sq_tid && blk[i].seq > sq_seq)) tmp.push_back(blk[i]);
      blk = tmp;
    end
    if (flush) begin
      rty = {};
      blk = {};
    end else begin
      if (push_valid) blk.push_back('{tid: push_tid, seq: push_seq, tag: push_tag});
      if (cache_retry) begin
        foreach (blk[i]) rty.push_back(blk[i]);
        blk = {};
      end
    end
    prev_retry = cache_retry;
    prev_mask  = active_mask;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic set_push(logic [TAG_W-1:0] tag, logic [TID_W-1:0] tid);
    push_valid = 1; push_tag = tag; push_tid = tid; push_seq = seq_ctr;
    seq_ctr = seq_ctr + 1'b1;
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_inputs();
    push_tag = '0; push_seq = '0; push_tid = '0; sq_tid = '0; sq_seq = '0;
    active_mask = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "reset replay_valid", int'(replay_valid), 0);
    check("R9", "reset wake", int'(wake), 0);
    check("R9", "reset thread_retry", int'(thread_retry), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: parked entries stay hidden
    set_push(6'd10, 1'b0); step();
    set_push(6'd11, 1'b0); step();
    set_push(6'd12, 1'b0); step();
    step();
    check("R1", "hidden after push", int'(replay_valid), 0);

    // R2, R3, R4: release with both threads active, new push joins release
    cache_retry = 1; active_mask = 2'b11; set_push(6'd13, 1'b1); step();
    check("R2", "head after retry", int'(replay_tag), 10);
    check("R4", "forward mask", int'(thread_retry), 3);
    check("R3", "wake after retry", int'(wake), 1);
    step();
    check("R3", "wake single cycle", int'(wake), 0);

    // R6: take head and push it back refused again
    replay_take = 1; push_valid = 1; push_tag = 6'd10; push_tid = 1'b0; push_seq = 8'd0; step();
    replay_take = 1; step();
    replay_take = 1; step();
    replay_take = 1; step();
    check("R6", "re-blocked hidden", int'(replay_valid), 0);
    cache_retry = 1; active_mask = 2'b01; step();
    check("R6", "re-blocked replays after retry", int'(replay_tag), 10);
    check("R4", "forward partial mask", int'(thread_retry), 1);
    replay_take = 1; step();

    // R8: squash thread 0 above a middle sequence number
    seq_ctr = 8'd40;
    set_push(6'd20, 1'b0); step();  // seq 40
    set_push(6'd21, 1'b1); step();  // seq 41
    set_push(6'd22, 1'b0); step();  // seq 42
    cache_retry = 1; step();
    set_push(6'd23, 1'b0); step();  // seq 43, blocked
    sq_valid = 1; sq_tid = 1'b0; sq_seq = 8'd40; step();
    check("R8", "head kept (seq not above)", int'(replay_tag), 20);
    replay_take = 1; step();
    check("R8", "thread 1 entry kept", int'(replay_tag), 21);
    replay_take = 1; step();
    check("R8", "thread 0 younger removed", int'(replay_valid), 0);
    cache_retry = 1; step();
    check("R8", "blocked younger removed", int'(replay_valid), 0);

    // R9: flush clears both lists and drops a push
    set_push(6'd30, 1'b0); step();
    cache_retry = 1; step();
    set_push(6'd31, 1'b0); step();
    flush = 1; set_push(6'd32, 1'b1); step();
    check("R9", "flush empties retry", int'(replay_valid), 0);
    cache_retry = 1; step();
    check("R9", "flush empties blocked", int'(replay_valid), 0);

    // R10: fill all storage then drain in order
    for (int k = 0; k < DEPTH; k++) begin
      set_push(TAG_W'(k + 40), TID_W'(k % 2)); step();
    end
    cache_retry = 1; step();
    popped = 0;
    for (int k = 0; k < DEPTH; k++) begin
      check("R10", "full drain order", int'(replay_tag), k + 40);
      replay_take = 1; step();
    end
    check("R10", "drained count", popped, DEPTH);
    check("R5", "empty after drain", int'(replay_valid), 0);

    // Mixed sweep against the model.
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(99) < 45 && (blk.size() + rty.size()) < DEPTH)
        set_push(TAG_W'($urandom), TID_W'($urandom));
      cache_retry   = ($urandom_range(99) < 12);
      active_mask   = NTHR'($urandom);
      replay_take   = ($urandom_range(99) < 50);
      issued_any    = ($urandom_range(99) < 20);
      defer_pending = ($urandom_range(99) < 10);
      if ($urandom_range(99) < 6) begin
        sq_valid = 1; sq_tid = TID_W'($urandom);
        sq_seq = seq_ctr - SEQ_W'($urandom_range(DEPTH));
      end
      flush = ($urandom_range(999) < 8);
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule